// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block walks through the column addresses of one memory burst, beat by beat, the same way a synchronous DRAM steps its own internal column counter. A one-cycle start pulse carries the first column together with the burst length code and the ordering bit. From the next cycle on, the block presents one column per clock with a valid flag. A last flag marks the final beat of a burst of fixed length.

Bursts of 2, 4 and 8 beats stay inside an aligned group of columns. Sequential ordering counts up and wraps inside that group. Interleaved ordering XORs the beat number into the low column bits. A full-page burst visits every column of the page, wraps from the top column back to column 0 and continues until a stop pulse or a new start ends it. A start that arrives while a burst is running abandons the old burst and begins the new one at once. Length codes and code combinations that are not defined give a single-beat burst.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `beat_vld_o` and `last_o` are 0 and `col_o` is 0.
- R2: A start pulse sampled at a clock edge makes beat 0 appear after that edge: `beat_vld_o`=1 and `col_o` equals the start column. One beat follows per clock after that.
- R3: `len_code_i` is decoded as 0→1 beat, 1→2, 2→4, 3→8 and 7→full page (2^COL_W beats). `len_code_i` and `ilv_i` are captured only with a start pulse, so changes during a burst have no effect on it.
- R4: With `ilv_i`=0 and length L in {2,4,8}, beat k has column (start + k) mod L in its low log2(L) bits. The upper column bits keep the values of the start column.
- R5: With `ilv_i`=1 and length L in {2,4,8}, beat k has low log2(L) bits equal to the start column's low bits XOR k. The upper bits are unchanged.
- R6: For a fixed length L, `last_o` is 1 exactly on beat L-1. Unless a new start is sampled, `beat_vld_o` is 0 in the following cycle.
- R7: A full-page burst goes on past the top column: beat k has column (start + k) mod 2^COL_W. `last_o` stays 0 for the whole burst.
- R8: A stop pulse sampled while a burst runs, with no start in the same cycle, makes `beat_vld_o` 0 after that edge. A stop pulse while idle has no effect.
- R9: A start pulse sampled during a burst restarts at beat 0 with the new column and mode. A start wins over a stop sampled in the same cycle.
- R10: Length codes 4, 5 and 6, and code 7 combined with `ilv_i`=1, each give a one-beat burst with `last_o`=1 on that beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begins a burst at `start_col_i` |
| start_col_i | input | COL_W | First column of the burst |
| stop_i | input | 1 | Ends the running burst early |
| len_code_i | input | 3 | Burst length code (see R3) |
| ilv_i | input | 1 | Ordering: 0 sequential, 1 interleaved |
| col_o | output | COL_W | Column of the current beat |
| beat_vld_o | output | 1 | A beat is presented this cycle |
| last_o | output | 1 | Current beat is the final one of a fixed-length burst |

## Verification
The assertions check on every cycle that a start loads beat 0 and a stop or a final beat empties the sequencer. They also check that the beat counter steps by one, that the upper column bits stay fixed inside a fixed-length burst, and that a full-page burst never raises the last flag. The exact column order in each mode, the length decoding, the wrap from the top column to zero, the capture of the mode at start and the reserved combinations can only be shown by the bench. It compares every cycle against an arithmetic model built on modulo and XOR.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  localparam int LEN_CODE_W = 3;

  typedef enum logic [LEN_CODE_W-1:0] {
    BLEN_ONE   = 3'd0,
    BLEN_TWO   = 3'd1,
    BLEN_FOUR  = 3'd2,
    BLEN_EIGHT = 3'd3,
    BLEN_PAGE  = 3'd7
  } blen_e;
endpackage

// File: rtl/burst_mode_dec.sv
module burst_mode_dec
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [LEN_CODE_W-1:0] len_code_i,
  input  logic                  ilv_i,
  output logic [COL_W-1:0]      mask_o,
  output logic                  ilv_o,
  output logic                  full_o
);
  // low-bit mask of a fixed burst; all ones for a full page
  function automatic logic [COL_W-1:0] len_mask(input logic [LEN_CODE_W-1:0] code,
                                                input logic ilv);
    logic [COL_W-1:0] m;
    case (code)
      BLEN_TWO:   m = COL_W'(1);
      BLEN_FOUR:  m = COL_W'(3);
      BLEN_EIGHT: m = COL_W'(7);
      BLEN_PAGE:  m = ilv ? '0 : '1;
      default:    m = '0;
    endcase
    return m;
  endfunction

  always_comb begin
    mask_o = len_mask(len_code_i, ilv_i);
    full_o = (len_code_i == BLEN_PAGE) && !ilv_i;
    ilv_o  = ilv_i && (mask_o != '0);
  end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  input  logic             full_i,
  output logic             active_o,
  output logic [COL_W-1:0] cnt_o,
  output logic [COL_W-1:0] base_o,
  output logic [COL_W-1:0] mask_o,
  output logic             ilv_o,
  output logic             full_o,
  output logic             last_o
);
  logic             active_q;
  logic [COL_W-1:0] cnt_q, base_q, mask_q;
  logic             ilv_q, full_q;
  logic             end_beat;

  assign end_beat = active_q && !full_q && (cnt_q == mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      base_q   <= '0;
      mask_q   <= '0;
      ilv_q    <= 1'b0;
      full_q   <= 1'b0;
    end else if (start_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      base_q   <= start_col_i;
      mask_q   <= mask_i;
      ilv_q    <= ilv_i;
      full_q   <= full_i;
    end else if (active_q) begin
      if (stop_i || end_beat) begin
        active_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + COL_W'(1);
      end
    end
  end

  assign active_o = active_q;
  assign cnt_o    = cnt_q;
  assign base_o   = base_q;
  assign mask_o   = mask_q;
  assign ilv_o    = ilv_q;
  assign full_o   = full_q;
  assign last_o   = end_beat;

  assert_start_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (active_q && cnt_q == '0));
  assert_start_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && stop_i) |=> active_q);
  assert_stop_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && stop_i && !start_i) |=> !active_q);
  assert_end_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (end_beat && !start_i) |=> !active_q);
  assert_step_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !start_i && !stop_i && !end_beat) |=> (cnt_q == $past(cnt_q) + COL_W'(1)));
endmodule

// File: rtl/burst_col_calc.sv
module burst_col_calc #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] cnt_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o
);
  function automatic logic [COL_W-1:0] seq_col(input logic [COL_W-1:0] b,
                                               input logic [COL_W-1:0] k,
                                               input logic [COL_W-1:0] m);
    return (b & ~m) | ((b + k) & m);
  endfunction

  function automatic logic [COL_W-1:0] ilv_col(input logic [COL_W-1:0] b,
                                               input logic [COL_W-1:0] k,
                                               input logic [COL_W-1:0] m);
    return (b & ~m) | ((b ^ k) & m);
  endfunction

  assign col_o = ilv_i ? ilv_col(base_i, cnt_i, mask_i)
                       : seq_col(base_i, cnt_i, mask_i);
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [COL_W-1:0]      start_col_i,
  input  logic                  stop_i,
  input  logic [LEN_CODE_W-1:0] len_code_i,
  input  logic                  ilv_i,
  output logic [COL_W-1:0]      col_o,
  output logic                  beat_vld_o,
  output logic                  last_o
);
  logic [COL_W-1:0] dec_mask;
  logic             dec_ilv, dec_full;
  logic             act;
  logic [COL_W-1:0] cnt, base, mask;
  logic             ilv_q, full_q, end_beat;
  logic [COL_W-1:0] col_raw;

  burst_mode_dec #(.COL_W(COL_W)) u_dec (
    .len_code_i (len_code_i),
    .ilv_i      (ilv_i),
    .mask_o     (dec_mask),
    .ilv_o      (dec_ilv),
    .full_o     (dec_full)
  );

  burst_beat_ctr #(.COL_W(COL_W)) u_ctr (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .start_col_i (start_col_i),
    .mask_i      (dec_mask),
    .ilv_i       (dec_ilv),
    .full_i      (dec_full),
    .active_o    (act),
    .cnt_o       (cnt),
    .base_o      (base),
    .mask_o      (mask),
    .ilv_o       (ilv_q),
    .full_o      (full_q),
    .last_o      (end_beat)
  );

  burst_col_calc #(.COL_W(COL_W)) u_calc (
    .base_i (base),
    .cnt_i  (cnt),
    .mask_i (mask),
    .ilv_i  (ilv_q),
    .col_o  (col_raw)
  );

  assign col_o      = act ? col_raw : '0;
  assign beat_vld_o = act;
  assign last_o     = end_beat;

  assert_page_no_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_vld_o && full_q) |-> !last_o);
  assert_last_needs_vld_R6: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> beat_vld_o);
  assert_upper_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_vld_o && !full_q && !$past(start_i) && $past(beat_vld_o))
      |-> ((col_o & ~mask) == ($past(col_o) & ~mask)));
  assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_vld_o |-> (col_o == '0 && !last_o));
endmodule

// File: tb/test_burst_col_seq.sv
module test_burst_col_seq;
  localparam int COL_W  = 8;
  localparam int PERIOD = 10;
  localparam int PAGE   = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [COL_W-1:0] start_col_i = '0;
  logic             stop_i = 1'b0;
  logic [2:0]       len_code_i = 3'd0;
  logic             ilv_i = 1'b0;
  logic [COL_W-1:0] col_o;
  logic             beat_vld_o, last_o;

  int total = 0;
  int bad = 0;
  string tag = "R1";

  burst_col_seq #(.COL_W(COL_W)) i_burst_col_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .stop_i(stop_i), .len_code_i(len_code_i), .ilv_i(ilv_i),
    .col_o(col_o), .beat_vld_o(beat_vld_o), .last_o(last_o)
  );

  always #(PERIOD/2) clk = ~clk;

  // behavioural reference: integers and modulo arithmetic
  int m_on = 0, m_k = 0, m_base = 0, m_len = 1, m_ilv = 0, m_page = 0;

  function automatic int len_of(input int code, input int ilv);
    if (code == 1) return 2;
    if (code == 2) return 4;
    if (code == 3) return 8;
    if (code == 7 && ilv == 0) return PAGE;
    return 1;
  endfunction

  function automatic int exp_col();
    int lowpart;
    if (m_page != 0) return (m_base + m_k) % PAGE;
    lowpart = m_base % m_len;
    if (m_ilv != 0) return m_base - lowpart + (lowpart ^ m_k);
    return m_base - lowpart + ((lowpart + m_k) % m_len);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_on = 0; m_k = 0;
    end else if (start_i) begin
      m_on = 1; m_k = 0; m_base = int'(start_col_i);
      m_len = len_of(int'(len_code_i), int'(ilv_i));
      m_page = (m_len == PAGE) ? 1 : 0;
      m_ilv = (ilv_i && m_len > 1) ? 1 : 0;
    end else if (m_on != 0) begin
      if (stop_i) m_on = 0;
      else if (m_page == 0 && m_k == m_len - 1) m_on = 0;
      else m_k = (m_k + 1) % PAGE;
    end
  end

  always @(negedge clk) begin
    int ec, el;
    if (rst_n) begin
      ec = (m_on != 0) ? exp_col() : 0;
      el = (m_on != 0 && m_page == 0 && m_k == m_len - 1) ? 1 : 0;
      total++;
      if (beat_vld_o !== (m_on != 0) || int'(col_o) != ec || int'(last_o) != el) begin
        bad++;
        $display("FAIL %s: vld=%0b col=%0d last=%0b expected vld=%0b col=%0d last=%0b",
                 tag, beat_vld_o, col_o, last_o, (m_on != 0), ec, el);
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      start_i = 1'b0; stop_i = 1'b0;
    end
  endtask

  task automatic go(input int col, input int code, input bit ilv);
    @(negedge clk);
    start_i = 1'b1; stop_i = 1'b0;
    start_col_i = COL_W'(col); len_code_i = 3'(code); ilv_i = ilv;
  endtask

  task automatic halt();
    @(negedge clk);
    start_i = 1'b0; stop_i = 1'b1;
  endtask

  initial begin
    #(PERIOD * 120000);
    bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state observed during reset
    repeat (3) @(negedge clk);
    total++;
    if (beat_vld_o !== 1'b0 || last_o !== 1'b0 || col_o !== '0) begin
      bad++;
      $display("FAIL R1: vld=%0b last=%0b col=%0d expected 0 0 0", beat_vld_o, last_o, col_o);
    end
    rst_n = 1'b1;
    idle(2);

    tag = "R4"; go(8'h2D, 3, 0); idle(10);
    tag = "R5"; go(8'h2D, 3, 1); idle(10);
    tag = "R4"; go(8'h13, 1, 0); idle(3); go(8'h16, 2, 0); idle(6);
    tag = "R5"; go(8'h13, 1, 1); idle(3); go(8'h16, 2, 1); idle(6);
    tag = "R6"; go(8'h40, 0, 0); idle(3);
    tag = "R2"; go(8'hFE, 3, 0); go(8'h07, 2, 1); idle(6);
    // R3: mode inputs change mid-burst, must be ignored
    tag = "R3"; go(8'h31, 3, 0);
    @(negedge clk); start_i = 1'b0; len_code_i = 3'd1; ilv_i = 1'b1;
    idle(9);
    // R7: full page wraps past the top column
    tag = "R7"; go(250, 7, 0); idle(PAGE + 20);
    tag = "R8"; halt(); idle(3);
    tag = "R8"; halt(); idle(2);
    tag = "R8"; go(8'h50, 3, 1); idle(2); halt(); idle(4);
    // R9: restart and start-beats-stop
    tag = "R9"; go(8'h60, 3, 0); idle(2); go(8'h82, 2, 1); idle(2);
    @(negedge clk); start_i = 1'b1; stop_i = 1'b1; start_col_i = 8'hA5;
    len_code_i = 3'd2; ilv_i = 1'b0;
    idle(6);
    // R10: reserved codes become single beats
    tag = "R10"; go(8'h33, 4, 0); idle(2); go(8'h34, 5, 1); idle(2);
    go(8'h35, 6, 0); idle(2); go(8'h36, 7, 1); idle(3);
    tag = "R6"; go(8'hFF, 1, 0); idle(4);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule